// File: doc/BRIEF.md
# SPI Host Controller with Register Access

This block is a memory-mapped SPI master that sends and receives one 8-bit frame per write to its transmit register. Software reaches it over a plain 32-bit register bus with an address, write and read strobes, write data and combinational read data. It drives SCK, MOSI and an active-low chip select, and samples MISO. The chip-select pin follows a register bit directly, so software frames multi-byte transfers itself.

The SCK rate comes from two divider stages in series. The first stage is a fixed prescaler of 16 or 128. The second stage divides by 2×(N+1), with a 5-bit N. Clock polarity and clock phase are chosen in the control register. The settings are captured when a frame starts.

Each SCK half period therefore lasts P×(N+1) input clock cycles, where P is the prescale. Two status flags report the block's state. The transmit-busy flag says whether a new byte may be written. The receive-full flag says that a received byte is waiting to be read.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the receive buffer reads 0 and the system-control register reads 0x40. The chip-select pin is high, SCK is low and MOSI is low.
- R2: Register word offsets are control 0x00, status 0x04, system control 0x08, transmit buffer 0x0C, receive buffer 0x10 and second control 0x14. Control bit 7 is CPHA, bit 6 is CPOL, bit 5 selects the prescale and bits 4:0 hold N. Control and system control read back what was written in bits 7:0. Second control always reads 0.
- R3: During a frame, every SCK half period lasts P×(N+1) clock cycles. P is 128 when control bit 5 is 1 and 16 when it is 0.
- R4: The chip-select pin equals system-control bit 6 from the cycle after that register is written. A 0 drives the pin low (asserted) and a 1 drives it high.
- R5: While no frame is running, SCK sits at the level of control bit 6 (CPOL).
- R6: Writing the transmit buffer while status bit 0 is 0 starts an 8-bit frame with 16 SCK edges, sent most-significant bit first. Status bit 0 reads 1 from the cycle after that write until the frame ends. A transmit write made while status bit 0 is 1 is ignored.
- R7: With CPHA=0, MOSI holds bit 7 before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R8: When a frame ends, the eight sampled MISO bits, first bit in the MSB, become readable at the receive buffer and status bit 2 is set.
- R9: A read of the receive buffer clears status bit 2. If that read falls in the same cycle as the end of a frame, bit 2 stays set and the buffer holds the new byte.
- R10: Any write to the status register clears both flags. A frame in progress stops and SCK returns to its idle level with no further edges. This write takes priority over a frame ending in the same cycle.
- R11: Divider, polarity and phase settings are captured when a frame starts. A control write made during a frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the SCK divider input |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; only side effect is on the receive buffer |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench checks the exact cycle length of SCK half periods across both prescales and the largest N. A divider off by one stage or by one count would show a gap that differs from P×(N+1). It runs all four CPOL/CPHA combinations against a device model that shifts on the opposite edge to the one where it samples. A sample or shift placed on the wrong edge would return a byte shifted by one position, or corrupt the byte seen on MOSI. Three further corner cases are placed on exact cycles: a transmit write during a busy frame, a status write in mid-frame, and a receive-buffer read in the same cycle as a frame end. A design that restarts on the extra write, keeps clocking after the abort, or lets the read win over the new byte would be caught.

// File: rtl/spi_host_pkg.sv
// Shared constants and the frame configuration type of the SPI host.
// Assumes the control byte layout {cpha, cpol, pre_hi, div_n}.
package spi_host_pkg;
    localparam int FRAME_W = 8;
    localparam int DIV_W   = 5;

    // Register word indices (byte offset / 4).
    localparam int IDX_CTRL  = 0;
    localparam int IDX_STAT  = 1;
    localparam int IDX_SYS   = 2;
    localparam int IDX_TXB   = 3;
    localparam int IDX_RXB   = 4;
    localparam int IDX_CTRL2 = 5;

    // Status bit positions.
    localparam int STAT_BUSY = 0;
    localparam int STAT_FULL = 2;

    // Chip-select bit within system control, and its reset value.
    localparam int          SYS_CS_BIT = 6;
    localparam logic [7:0]  SYS_RESET  = 8'h40;

    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic             pre_hi;
        logic [DIV_W-1:0] div_n;
    } frame_cfg_t;
endpackage

// File: rtl/spi_host_clkgen.sv
// Two-stage SCK half-period timer: a fixed prescaler (PRE_LO or PRE_HI)
// followed by an (N+1) counter. It emits one tick per half period.
// Assumes pre_hi and div_n stay stable while run is high; counters rest at 0 when idle.
module spi_host_clkgen #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128,
    parameter int DIV_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_hi,
    input  logic [DIV_W-1:0] div_n,
    output logic             half_tick
);
    localparam int PRE_MAX = (PRE_HI > PRE_LO) ? PRE_HI : PRE_LO;
    localparam int PRE_W   = $clog2(PRE_MAX);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic [DIV_W-1:0] div_cnt;

    // Select the terminal count of the first stage.
    always_comb begin
        pre_lim = pre_hi ? PRE_W'(PRE_HI - 1) : PRE_W'(PRE_LO - 1);
    end

    // Advance the prescaler, and the second stage on each prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_cnt == pre_lim) begin
            pre_cnt <= '0;
            div_cnt <= (div_cnt == div_n) ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // A half period ends when both stages are at their terminal count.
    always_comb begin
        half_tick = run && (pre_cnt == pre_lim) && (div_cnt == div_n);
    end

    // R3: the second stage never passes its programmed limit during a frame.
    a_r3_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_cnt <= div_n));
endmodule

// File: rtl/spi_host_shifter.sv
// Frame engine: captures the configuration at start, walks 2*FRAME_W SCK
// edges, shifts MOSI out MSB first and MISO in, and pulses done at the last edge.
// Assumes start is only raised while not busy; abort overrides everything.
module spi_host_shifter
    import spi_host_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [FW-1:0]    tx_byte,
    input  frame_cfg_t       cfg_in,
    input  logic             half_tick,
    input  logic             miso,
    output logic             busy,
    output logic             cpol_q,
    output logic             pre_hi_q,
    output logic [DIV_W-1:0] div_n_q,
    output logic             sck_ph,
    output logic             mosi,
    output logic             done,
    output logic [FW-1:0]    rx_byte
);
    localparam int EDGES  = 2 * FW;
    localparam int EDGE_W = $clog2(EDGES);

    frame_cfg_t        cfg_q;
    logic              busy_q;
    logic              ph_q;
    logic              mosi_q;
    logic [EDGE_W-1:0] edge_cnt;
    logic [FW-1:0]     tx_sh;
    logic [FW-1:0]     rx_sh;
    logic [FW-1:0]     rx_next;
    logic              lead;
    logic              last;
    logic              sample_now;
    logic              drive_now;

    // Classify the coming edge as sample or drive for the latched phase.
    always_comb begin
        lead       = !ph_q;
        last       = (edge_cnt == EDGE_W'(EDGES - 1));
        sample_now = busy_q && half_tick && (cfg_q.cpha ? !lead : lead);
        drive_now  = busy_q && half_tick && (cfg_q.cpha ? lead : (!lead && !last));
        rx_next    = {rx_sh[FW-2:0], miso};
        done       = busy_q && half_tick && last;
        rx_byte    = sample_now ? rx_next : rx_sh;
    end

    // Frame state: start, edge walking, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            busy_q   <= 1'b0;
            ph_q     <= 1'b0;
            mosi_q   <= 1'b0;
            edge_cnt <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
        end else if (abort) begin
            busy_q   <= 1'b0;
            ph_q     <= 1'b0;
            edge_cnt <= '0;
        end else if (start) begin
            busy_q   <= 1'b1;
            cfg_q    <= cfg_in;
            ph_q     <= 1'b0;
            edge_cnt <= '0;
            rx_sh    <= '0;
            if (cfg_in.cpha) begin
                tx_sh  <= tx_byte;
            end else begin
                mosi_q <= tx_byte[FW-1];
                tx_sh  <= {tx_byte[FW-2:0], 1'b0};
            end
        end else if (busy_q && half_tick) begin
            ph_q     <= !ph_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (last) begin
                busy_q <= 1'b0;
            end
            if (sample_now) begin
                rx_sh <= rx_next;
            end
            if (drive_now) begin
                mosi_q <= tx_sh[FW-1];
                tx_sh  <= {tx_sh[FW-2:0], 1'b0};
            end
        end
    end

    // Expose the latched settings and pin levels.
    always_comb begin
        busy     = busy_q;
        cpol_q   = cfg_q.cpol;
        pre_hi_q = cfg_q.pre_hi;
        div_n_q  = cfg_q.div_n;
        sck_ph   = ph_q;
        mosi     = mosi_q;
    end

    // R5: the clock phase is back at idle whenever no frame runs.
    a_r5_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !ph_q);
    // R6: an accepted start makes the engine busy.
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> busy_q);
    // R10: an abort leaves the engine idle.
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy_q && !ph_q));
    // R11: captured settings do not move during a frame.
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(cfg_q));
endmodule

// File: rtl/spi_host_csr.sv
// Register file of the SPI host: decodes the bus, holds control, system
// control, the transmit and receive bytes and the receive-full flag.
// Assumes single-cycle strobes and DATA_W >= 8; bits 1:0 of the address are ignored.
module spi_host_csr
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int FW     = FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [FW-1:0]     rx_byte,
    output logic              start,
    output logic              abort,
    output logic [FW-1:0]     tx_byte,
    output frame_cfg_t        cfg,
    output logic              cs_n
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [7:0]       ctrl_q;
    logic [7:0]       sys_q;
    logic [FW-1:0]    txb_q;
    logic [FW-1:0]    rxb_q;
    logic             full_q;
    logic             wr_ctrl, wr_sys, wr_txb, wr_stat, rd_rxb;
    logic             unused_bits;

    // Decode the word index into per-register strobes.
    always_comb begin
        idx     = addr[ADDR_W-1:2];
        wr_ctrl = wr_en && (idx == IDX_W'(IDX_CTRL));
        wr_stat = wr_en && (idx == IDX_W'(IDX_STAT));
        wr_sys  = wr_en && (idx == IDX_W'(IDX_SYS));
        wr_txb  = wr_en && (idx == IDX_W'(IDX_TXB));
        rd_rxb  = rd_en && (idx == IDX_W'(IDX_RXB));
        start   = wr_txb && !busy;
        abort   = wr_stat;
        tx_byte = wdata[FW-1:0];
        cfg     = frame_cfg_t'(ctrl_q);
        cs_n    = sys_q[SYS_CS_BIT];
        unused_bits = ^{addr[1:0], wdata[DATA_W-1:8]};
    end

    // Hold the software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sys_q  <= SYS_RESET;
            txb_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[7:0];
            if (wr_sys)  sys_q  <= wdata[7:0];
            if (start)   txb_q  <= wdata[FW-1:0];
        end
    end

    // Receive buffer and flag: status write beats frame end beats read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxb_q  <= '0;
            full_q <= 1'b0;
        end else if (wr_stat) begin
            full_q <= 1'b0;
        end else if (done) begin
            rxb_q  <= rx_byte;
            full_q <= 1'b1;
        end else if (rd_rxb) begin
            full_q <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        case (idx)
            IDX_W'(IDX_CTRL): rdata[7:0] = ctrl_q;
            IDX_W'(IDX_STAT): begin
                rdata[STAT_BUSY] = busy;
                rdata[STAT_FULL] = full_q;
            end
            IDX_W'(IDX_SYS):  rdata[7:0]    = sys_q;
            IDX_W'(IDX_TXB):  rdata[FW-1:0] = txb_q;
            IDX_W'(IDX_RXB):  rdata[FW-1:0] = rxb_q;
            default:          rdata = '0;
        endcase
    end

    // R8: a frame end not overridden by a status write sets the flag.
    a_r8_full_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_stat) |=> full_q);
    // R9: a lone buffer read clears the flag.
    a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxb && !done && !wr_stat) |=> !full_q);
    // R10: a status write clears the flag.
    a_r10_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> !full_q);
endmodule

// File: rtl/spi_host_regs.sv
// Top of the SPI host: joins the register file, the SCK timer and the frame
// engine, and forms the SCK pin from the phase and the polarity.
// Assumes a single clock domain; MISO is already synchronous to clk.
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int IDX_W = ADDR_W - 2;

    logic             busy, done, start, abort;
    logic             half_tick, sck_ph, cpol_q, pre_hi_q;
    logic [DIV_W-1:0] div_n_q;
    logic [FRAME_W-1:0] tx_byte, rx_byte;
    frame_cfg_t       cfg_live;

    spi_host_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FW(FRAME_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
        .rx_byte(rx_byte), .start(start), .abort(abort), .tx_byte(tx_byte),
        .cfg(cfg_live), .cs_n(spi_cs_n)
    );

    spi_host_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(busy), .pre_hi(pre_hi_q), .div_n(div_n_q),
        .half_tick(half_tick)
    );

    spi_host_shifter #(.FW(FRAME_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .tx_byte(tx_byte),
        .cfg_in(cfg_live), .half_tick(half_tick), .miso(spi_miso), .busy(busy),
        .cpol_q(cpol_q), .pre_hi_q(pre_hi_q), .div_n_q(div_n_q), .sck_ph(sck_ph),
        .mosi(spi_mosi), .done(done), .rx_byte(rx_byte)
    );

    // SCK: latched polarity during a frame, live polarity when idle.
    always_comb begin
        spi_sck = busy ? (sck_ph ^ cpol_q) : cfg_live.cpol;
    end

    // R4: the chip-select pin follows the written system-control bit.
    a_r4_cs_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(IDX_SYS)))
        |=> (spi_cs_n == $past(bus_wdata[SYS_CS_BIT])));
endmodule

// File: tb/spi_host_regs_bench.sv
module spi_host_regs_bench;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SYS = 5'h08,
                           A_TXB = 5'h0C, A_RXB = 5'h10, A_CTRL2 = 5'h14;
    // {ctrl, tx byte, device byte}
    localparam logic [23:0] VECS [6] = '{
        24'h00A53C, 24'h40817E, 24'h805AC3, 24'hC2FF01, 24'h2000FF, 24'h9F6B94
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              spi_sck, spi_mosi, spi_cs_n;
    logic              spi_miso = 1'b0;

    int checks = 0, errors = 0, cyc = 0;

    spi_host_regs u_spi_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Device model: shifts on the edge opposite to its sampling edge.
    logic       arm = 1'b0, arm_seen = 1'b0, cpha_m = 1'b0, sck_prev = 1'b0;
    logic [7:0] dev_byte = '0, dev_sh = '0, cap = '0;
    int         ecnt = 0, last_t = -1, gmin = 0, gmax = 0;
    always @(negedge clk) begin
        if (arm != arm_seen) begin
            arm_seen = arm; ecnt = 0; dev_sh = dev_byte; spi_miso = dev_byte[7];
            gmin = 1000000; gmax = 0; last_t = -1; sck_prev = spi_sck; cap = '0;
        end else if (spi_sck != sck_prev) begin
            sck_prev = spi_sck;
            if (last_t >= 0) begin
                if (cyc - last_t < gmin) gmin = cyc - last_t;
                if (cyc - last_t > gmax) gmax = cyc - last_t;
            end
            last_t = cyc;
            if (((ecnt % 2) == 0) != cpha_m) cap = {cap[6:0], spi_mosi};
            else if (cpha_m) begin spi_miso = dev_sh[7]; dev_sh = {dev_sh[6:0], 1'b0}; end
            else begin dev_sh = {dev_sh[6:0], 1'b0}; spi_miso = dev_sh[7]; end
            ecnt = ecnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            peek(A_STAT, s);
            if (!s[0]) return;
        end
        chk("R6 frame end", 32'd1, 32'd0);
    endtask

    task automatic do_frame(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] dv);
        bus_write(A_CTRL, {24'h0, c});
        cpha_m = c[7]; dev_byte = dv; arm = ~arm;
        @(negedge clk);
        bus_write(A_TXB, {24'h0, tx});
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int h, e0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek(A_CTRL, d); chk("R1 ctrl", d, 0);
        peek(A_STAT, d); chk("R1 status", d, 0);
        peek(A_RXB, d);  chk("R1 rxbuf", d, 0);
        peek(A_SYS, d);  chk("R1 sysctl", d, 32'h40);
        chk("R1 cs_n", spi_cs_n, 1); chk("R1 sck", spi_sck, 0); chk("R1 mosi", spi_mosi, 0);
        // R4 chip select, R2 readback
        bus_write(A_SYS, 32'h21); @(negedge clk);
        chk("R4 cs low", spi_cs_n, 0);
        peek(A_SYS, d); chk("R2 sysctl readback", d, 32'h21);
        bus_write(A_CTRL2, 32'hFF); peek(A_CTRL2, d); chk("R2 ctrl2 zero", d, 0);
        bus_write(A_CTRL, 32'hC7); peek(A_CTRL, d); chk("R2 ctrl readback", d, 32'hC7);
        chk("R5 idle sck cpol1", spi_sck, 1);
        bus_write(A_SYS, 32'h61); @(negedge clk); chk("R4 cs high", spi_cs_n, 1);
        bus_write(A_SYS, 32'h21);
        // Vector table: R3 R6 R7 R8 R9 R5
        foreach (VECS[i]) begin
            logic [7:0] c, tx, dv;
            {c, tx, dv} = VECS[i];
            h = (c[5] ? 128 : 16) * (c[4:0] + 1);
            do_frame(c, tx, dv);
            chk("R3 min half period", gmin, h); chk("R3 max half period", gmax, h);
            chk("R6 edge count", ecnt, 16);
            chk("R7 mosi byte", cap, tx);
            peek(A_STAT, d); chk("R8 full flag", d, 32'h4);
            bus_read(A_RXB, d); chk("R8 rx byte", d, dv);
            peek(A_STAT, d); chk("R9 read clears", d, 0);
            chk("R5 sck idle", spi_sck, c[6]);
        end
        // R6 transmit write while busy is ignored
        bus_write(A_CTRL, 32'h00); cpha_m = 0; dev_byte = 8'h96; arm = ~arm; @(negedge clk);
        bus_write(A_TXB, 32'h3C);
        repeat (40) @(negedge clk);
        peek(A_STAT, d); chk("R6 busy mid frame", d[0], 1);
        bus_write(A_TXB, 32'hFF); wait_idle();
        chk("R6 ignored write mosi", cap, 8'h3C); chk("R6 ignored edges", ecnt, 16);
        bus_read(A_RXB, d); chk("R6 ignored write rx", d, 8'h96);
        // R11 control write during a frame
        arm = ~arm; @(negedge clk); bus_write(A_TXB, 32'h55);
        repeat (20) @(negedge clk); bus_write(A_CTRL, 32'h01); wait_idle();
        chk("R11 old divider kept", gmax, 16); chk("R11 old divider min", gmin, 16);
        arm = ~arm; @(negedge clk); bus_write(A_TXB, 32'h55); wait_idle();
        chk("R11 new divider used", gmin, 32);
        // R9 read in the same cycle as frame end: flag set, new byte kept
        bus_write(A_CTRL, 32'h00); dev_byte = 8'hA7; arm = ~arm; @(negedge clk);
        bus_write(A_TXB, 32'h11);
        repeat (255) @(negedge clk);
        bus_addr = A_RXB; bus_rd = 1'b1; @(negedge clk); bus_rd = 1'b0;
        peek(A_STAT, d); chk("R9 coincident read keeps flag", d, 32'h4);
        peek(A_RXB, d); chk("R9 coincident new byte", d, 8'hA7);
        // R10 status write aborts a frame
        bus_write(A_CTRL, 32'h43); dev_byte = 8'h0F; arm = ~arm; @(negedge clk);
        bus_write(A_TXB, 32'hF0);
        repeat (150) @(negedge clk);
        peek(A_STAT, d); chk("R10 busy before abort", d, 32'h5);
        bus_write(A_STAT, 32'h0);
        peek(A_STAT, d); chk("R10 flags cleared", d, 0);
        chk("R10 sck idle", spi_sck, 1);
        e0 = ecnt;
        repeat (200) @(negedge clk);
        chk("R10 no more edges", ecnt, e0);
        do_frame(8'h00, 8'hC5, 8'h5C);
        chk("R10 frame after abort mosi", cap, 8'hC5);
        bus_read(A_RXB, d); chk("R10 frame after abort rx", d, 8'h5C);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule